// File: doc/BRIEF.md
# Display Panel Register Write Sequencer

This block writes configuration registers of a display panel controller over a serial peripheral (SPI) link. A host asserts `start` for one cycle and supplies an operation code. A plain write takes a register number and a 16-bit value. Three canned operations run fixed command sequences: power-up, shutdown and resume.

Each register write is sent as two separate chip-select frames of three bytes each. The first frame names the register and the second carries the value. The block drives SPI mode 0, most significant bit first, with the serial clock derived from the system clock by a parameter. The host sees `busy` while a command is in flight and a one-cycle `done` when it has ended.

The panel's orientation-control word is built inside the block. A fixed default pattern has four option bits overwritten from a configuration input. This lets power-up and resume program the panel's scan direction and colour order without the host computing the word.

Top module: `panel_reg_writer`

## Requirements
- R1: While reset is asserted and after it is released with no command, `busy` and `done` are low, `cs_n` is high, and `sclk` and `mosi` are low.
- R2: With `op`=0 (plain write), the block sends an index frame of 24 bits {0x74, 0x00, `reg_addr`} followed by a data frame {0x76, `reg_value`[15:8], `reg_value`[7:0]}. Each frame is enclosed in its own low period of `cs_n`.
- R3: Frames use SPI mode 0, most significant bit first. `sclk` is low whenever `cs_n` is high, and `mosi` changes only while `sclk` is low. Every high phase of `sclk` lasts exactly HALF_DIV system clocks.
- R4: Between two consecutive frames of one command, `cs_n` stays high for at least one full serial clock period (2×HALF_DIV system clocks).
- R5: With `op`=1 (power-up), the block writes 0x0000 to register 0x11 and then writes the orientation word to register 0x01.
- R6: With `op`=2 (shutdown), the block writes 0x0001 to register 0x11.
- R7: With `op`=3 (resume), the block writes the orientation word to register 0x01 first and only then writes 0x0000 to register 0x11.
- R8: The orientation word is 0x2AEF with bits 13:10 replaced by `orient_opts`[3:0]. Bit 10 is left/right mirror, bit 11 is top/bottom mirror, bit 12 is blue-first colour order and bit 13 is reverse. `orient_opts` is sampled in the cycle `start` is accepted.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until the last frame has ended and its trailing gap has elapsed. `busy` falls in the same cycle that `done` is high for exactly one cycle.
- R10: A `start` while `busy` is high is ignored. It produces no extra frame and does not change the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command request |
| op | input | 2 | Command: 0 write, 1 power-up, 2 shutdown, 3 resume |
| reg_addr | input | 8 | Register number for a plain write |
| reg_value | input | 16 | Value for a plain write |
| orient_opts | input | 4 | Option bits placed into orientation word bits 13:10 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume the host drives `start` only as a single-cycle pulse. They also assume the command inputs are valid in the cycle that pulse is accepted; after that cycle the block holds its own copy. The stimulus keeps to this by changing inputs only on the falling clock edge and lowering `start` one cycle later. When `start` is pulsed mid-command, it is kept clear of the cycle in which a frame ends, so that an ignored request never coincides with an internal launch.

// File: rtl/panel_seq_pkg.sv
`timescale 1ns/1ps
package panel_seq_pkg;

  localparam int ADDR_W  = 8;
  localparam int VAL_W   = 16;
  localparam int OPT_W   = 4;
  localparam int FRAME_W = 8 + 8 + 8;

  localparam logic [7:0] INDEX_LEAD = 8'h74;
  localparam logic [7:0] DATA_LEAD  = 8'h76;

  localparam logic [ADDR_W-1:0] SLEEP_REG  = 8'h11;
  localparam logic [ADDR_W-1:0] ORIENT_REG = 8'h01;
  localparam logic [VAL_W-1:0]  SLEEP_ON   = 16'h0001;
  localparam logic [VAL_W-1:0]  SLEEP_OFF  = 16'h0000;

  localparam logic [VAL_W-1:0] ORIENT_BASE = 16'h2AEF;
  localparam int               OPT_LSB     = 10;

  typedef enum logic [1:0] {
    OP_WRITE    = 2'd0,
    OP_POWER_UP = 2'd1,
    OP_SHUTDOWN = 2'd2,
    OP_RESUME   = 2'd3
  } seq_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [VAL_W-1:0]  val;
  } reg_wr_t;

  typedef struct packed {
    logic    two;
    reg_wr_t first;
    reg_wr_t second;
  } wr_plan_t;

  // Orientation word: default pattern with the option field overwritten.
  function automatic logic [VAL_W-1:0] orient_word(input logic [OPT_W-1:0] opts);
    logic [VAL_W-1:0] mask;
    mask = VAL_W'({OPT_W{1'b1}}) << OPT_LSB;
    return (ORIENT_BASE & ~mask) | (VAL_W'(opts) << OPT_LSB);
  endfunction

  // One 24-bit frame: index phase or data phase of a register write.
  function automatic logic [FRAME_W-1:0] frame_of(input reg_wr_t w, input logic data_phase);
    if (data_phase) return {DATA_LEAD, w.val};
    return {INDEX_LEAD, 8'h00, w.addr};
  endfunction

  // Expand a command into one or two ordered register writes.
  function automatic wr_plan_t plan_of(input seq_op_e op, input logic [ADDR_W-1:0] addr,
                                       input logic [VAL_W-1:0] val,
                                       input logic [OPT_W-1:0] opts);
    wr_plan_t p;
    p = '0;
    case (op)
      OP_POWER_UP: begin
        p.two          = 1'b1;
        p.first.addr   = SLEEP_REG;
        p.first.val    = SLEEP_OFF;
        p.second.addr  = ORIENT_REG;
        p.second.val   = orient_word(opts);
      end
      OP_SHUTDOWN: begin
        p.first.addr   = SLEEP_REG;
        p.first.val    = SLEEP_ON;
      end
      OP_RESUME: begin
        p.two          = 1'b1;
        p.first.addr   = ORIENT_REG;
        p.first.val    = orient_word(opts);
        p.second.addr  = SLEEP_REG;
        p.second.val   = SLEEP_OFF;
      end
      default: begin
        p.first.addr   = addr;
        p.first.val    = val;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/panel_half_tick.sv
`timescale 1ns/1ps
module panel_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/panel_spi_framer.sv
`timescale 1ns/1ps
module panel_spi_framer
  import panel_seq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int GAP_HALVES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               fin
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  typedef enum logic [2:0] {
    FR_IDLE, FR_SETUP, FR_SHIFT, FR_HOLD, FR_GAP
  } fr_state_e;

  fr_state_e          state;
  logic [FRAME_W-1:0] shreg;
  logic [BIT_W-1:0]   bit_idx;
  logic [GAP_W-1:0]   gap_cnt;
  logic               sclk_q, cs_q, fin_q;
  logic               tick;

  panel_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state != FR_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (state)
        FR_IDLE: if (go) begin
          shreg   <= frame;
          bit_idx <= '0;
          cs_q    <= 1'b0;
          state   <= FR_SETUP;
        end
        FR_SETUP: if (tick) begin
          sclk_q <= 1'b1;
          state  <= FR_SHIFT;
        end
        FR_SHIFT: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            if (bit_idx == BIT_W'(FRAME_W - 1)) begin
              state <= FR_HOLD;
            end else begin
              shreg   <= shreg << 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            sclk_q <= 1'b1;
          end
        end
        FR_HOLD: if (tick) begin
          cs_q    <= 1'b1;
          gap_cnt <= '0;
          state   <= FR_GAP;
        end
        FR_GAP: if (tick) begin
          if (gap_cnt == GAP_W'(GAP_HALVES - 1)) begin
            state <= FR_IDLE;
            fin_q <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = !cs_q && shreg[FRAME_W-1];
  assign fin  = fin_q;

endmodule

// File: rtl/panel_seq_ctrl.sv
`timescale 1ns/1ps
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [VAL_W-1:0]   val,
  input  logic [OPT_W-1:0]   opts,
  input  logic               fin,
  output logic               go,
  output logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               done
);

  wr_plan_t   plan_q;
  logic [1:0] step;
  logic       busy_q, done_q, go_q;
  logic       accept, last_step;

  assign accept    = start && !busy_q;
  assign last_step = plan_q.two ? (step == 2'd3) : (step == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q <= '0;
      step   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      go_q   <= 1'b0;
      if (accept) begin
        plan_q <= plan_of(seq_op_e'(op), addr, val, opts);
        step   <= '0;
        busy_q <= 1'b1;
        go_q   <= 1'b1;
      end else if (busy_q && fin) begin
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step <= step + 1'b1;
          go_q <= 1'b1;
        end
      end
    end
  end

  assign frame = frame_of(step[1] ? plan_q.second : plan_q.first, step[0]);
  assign go    = go_q;
  assign busy  = busy_q;
  assign done  = done_q;

endmodule

// File: rtl/panel_reg_writer.sv
`timescale 1ns/1ps
module panel_reg_writer
  import panel_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_value,
  input  logic [3:0]  orient_opts,
  output logic        busy,
  output logic        done,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);

  // Internal events brought out by name for the bound checker.
  logic               launch;
  logic               frame_done;
  logic [FRAME_W-1:0] next_frame;

  panel_seq_ctrl u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .op   (op),
    .addr (reg_addr),
    .val  (reg_value),
    .opts (orient_opts),
    .fin  (frame_done),
    .go   (launch),
    .frame(next_frame),
    .busy (busy),
    .done (done)
  );

  panel_spi_framer #(.HALF_DIV(HALF_DIV), .GAP_HALVES(2)) u_framer (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (launch),
    .frame(next_frame),
    .sclk (sclk),
    .mosi (mosi),
    .cs_n (cs_n),
    .fin  (frame_done)
  );

endmodule

// File: rtl/panel_reg_writer_chk.sv
`timescale 1ns/1ps
module panel_reg_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic launch,
  input logic frame_done
);

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R9
  cs_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cs_n);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_done) |=> !launch);

endmodule

bind panel_reg_writer panel_reg_writer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .sclk      (sclk),
  .mosi      (mosi),
  .cs_n      (cs_n),
  .launch    (launch),
  .frame_done(frame_done)
);

// File: tb/sim_panel_reg_writer.sv
`timescale 1ns/1ps
module sim_panel_reg_writer;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_value = 16'h0000;
  logic [3:0]  orient_opts = 4'h0;
  wire         busy, done, sclk, mosi, cs_n;

  always #2.5 clk = ~clk;

  panel_reg_writer #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_addr(reg_addr),
    .reg_value(reg_value), .orient_opts(orient_opts), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  int          vectors = 0;
  int          miscompares = 0;
  logic [23:0] expq[$];
  string       cur_req = "R2";
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Behavioural serial receiver: mode 0, most significant bit first.
  logic [23:0] rx_sh;
  logic [23:0] exp_f;
  int          rx_bits = 0;
  bit          rx_act = 0;
  int          cmd_frames = 0;

  always @(negedge cs_n) begin
    rx_act  = 1;
    rx_bits = 0;
    rx_sh   = '0;
  end

  always @(posedge sclk) if (rx_act) begin
    rx_sh = {rx_sh[22:0], mosi};
    rx_bits++;
  end

  always @(posedge cs_n) if (rx_act) begin
    rx_act = 0;
    cmd_frames++;
    chk(rx_bits == 24, "R2", "bits per frame", rx_bits, 24);
    if (expq.size() == 0) begin
      chk(0, "R10", "unexpected frame", int'(rx_sh), 0);
    end else begin
      exp_f = expq.pop_front();
      chk(rx_sh == exp_f, cur_req, "frame content", int'(rx_sh), int'(exp_f));
    end
  end

  // Per-clock protocol comparison.
  int hi_run = 0;
  int cs_hi  = 0;
  bit prev_cs = 1;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) chk(!sclk, "R3", "sclk idle while deselected", sclk, 0);
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      chk(hi_run == HALF, "R3", "sclk high phase length", hi_run, HALF);
      hi_run = 0;
    end
    if (cs_n) cs_hi++;
    else begin
      if (prev_cs && cmd_frames > 0)
        chk(cs_hi >= 2 * HALF, "R4", "chip-select gap", cs_hi, 2 * HALF);
      cs_hi = 0;
    end
    prev_cs = cs_n;
  end

  function automatic logic [15:0] exp_orient(input logic [3:0] o);
    logic [15:0] w;
    w = 16'h2AEF;
    for (int i = 0; i < 4; i++) w[10 + i] = o[i];
    return w;
  endfunction

  task automatic expect_write(input logic [7:0] a, input logic [15:0] v);
    expq.push_back({8'h74, 8'h00, a});
    expq.push_back({8'h76, v[15:8], v[7:0]});
  endtask

  task automatic run_cmd(input logic [1:0] o, input logic [7:0] a, input logic [15:0] v,
                         input logic [3:0] opt, input string req, input bit poke);
    cur_req    = req;
    cmd_frames = 0;
    @(negedge clk);
    op = o; reg_addr = a; reg_value = v; orient_opts = opt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    orient_opts = ~opt;  // R8: later changes must not matter
    reg_addr = 8'hC3;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      op = 2'd0; reg_addr = 8'hEE; reg_value = 16'h1234; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy kept during ignored start", busy, 1);
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    chk(cs_n == 1'b1, "R9", "chip select released at done", cs_n, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    chk(expq.size() == 0, req, "frames outstanding", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 0 && done == 0, "R1", "handshake in reset", {busy, done}, 0);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R1", "serial pins in reset",
        {cs_n, sclk, mosi}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 after release, idle
    chk(busy == 0 && done == 0 && cs_n == 1 && sclk == 0 && mosi == 0, "R1",
        "idle after reset", {busy, done, cs_n, sclk, mosi}, 5'b00100);

    // R2 plain writes with varied patterns and boundaries
    expect_write(8'h5A, 16'hBEEF);
    run_cmd(2'd0, 8'h5A, 16'hBEEF, 4'h0, "R2", 0);
    expect_write(8'hFF, 16'h0000);
    run_cmd(2'd0, 8'hFF, 16'h0000, 4'h0, "R2", 0);
    expect_write(8'h00, 16'hFFFF);
    run_cmd(2'd0, 8'h00, 16'hFFFF, 4'h0, "R2", 0);

    // R5 power-up, R8 option field both extremes
    expect_write(8'h11, 16'h0000);
    expect_write(8'h01, exp_orient(4'h0));
    run_cmd(2'd1, 8'h00, 16'h0000, 4'h0, "R5", 0);
    expect_write(8'h11, 16'h0000);
    expect_write(8'h01, exp_orient(4'hF));
    run_cmd(2'd1, 8'h00, 16'h0000, 4'hF, "R8", 0);

    // R6 shutdown
    expect_write(8'h11, 16'h0001);
    run_cmd(2'd2, 8'h77, 16'h5555, 4'h3, "R6", 0);

    // R7 resume ordering, R8 mixed options
    expect_write(8'h01, exp_orient(4'h5));
    expect_write(8'h11, 16'h0000);
    run_cmd(2'd3, 8'h00, 16'h0000, 4'h5, "R7", 0);

    // R10 start while busy is ignored
    expect_write(8'h3C, 16'hA5C3);
    run_cmd(2'd0, 8'h3C, 16'hA5C3, 4'h0, "R10", 1);
    repeat (300) @(negedge clk);
    chk(busy == 0 && cs_n == 1 && expq.size() == 0, "R10", "quiet after ignored start",
        {busy, cs_n}, 2'b01);

    wrap_up();
  end

endmodule